// File: doc/BRIEF.md
# Interrupt Controller System Register Access Classifier

This block decides what happens to one access to an interrupt-controller system register. It looks at the privilege level the access comes from (0 to 3), whether a hypervisor level is enabled, whether a monitor level exists and whether that monitor runs in 32-bit state. It also looks at the security state, the monitor-mode flag and a set of control bits. From these it produces exactly one verdict: undefined, trap to level 2, trap to level 3, use the virtual copy, use the secure copy, use the non-secure copy, or use the single shared copy when there is no monitor level.

The decoder is purely combinational and holds no state. Each privilege level has its own priority-ordered chain of checks. The level-1 chain is the longest: it mixes undefined results, traps to two different levels and virtual redirection before it finally picks a bank. Every trap verdict also drives a fixed exception-class code, which the exception-entry logic that follows uses. That exception-entry logic is not part of this block.

Top module: `sysreg_access_classifier`

## Requirements
- R1: An access with `priv_lvl` = 0 always gives the undefined verdict, whatever the other inputs are.
- R2: At level 1, `hyp_on` = 1 together with `grp_trap` = 1 gives trap-to-level-2. This takes precedence over every other level-1 check.
- R3: At level 1, when R2 does not apply and `sre_lvl1` = 0, the verdict is undefined.
- R4: At level 1, when R2 and R3 do not apply, `hyp_on` = 1 together with `trap_all` = 1 gives trap-to-level-2.
- R5: At level 1, when R2 to R4 do not apply, `hyp_on` = 1 together with `virt_route` = 1 gives the virtual-copy verdict.
- R6: At level 1, when R2 to R5 do not apply, `mon_impl` = 1 together with `irq_to_mon` = 1 gives trap-to-level-3. There is one exception: when `mon_is32` = 1 and `in_mon_mode` = 1, this trap does not happen.
- R7: At level 1, when no earlier check applies, the bank is chosen as follows. With `mon_impl` = 1, `nonsec` = 0 selects the secure copy and `nonsec` = 1 selects the non-secure copy. With `mon_impl` = 0, the single copy is used.
- R8: At level 2, `sre_lvl2` = 0 gives undefined. Otherwise, `mon_impl` = 1 together with `irq_to_mon` = 1 gives trap-to-level-3. Otherwise the non-secure copy is used when `mon_impl` = 1, and the single copy when `mon_impl` = 0. At this level `hyp_on`, `grp_trap`, `trap_all` and `virt_route` have no effect.
- R9: At level 3, `sre_lvl3` = 0 gives undefined. Otherwise `nonsec` = 0 selects the secure copy and `nonsec` = 1 selects the non-secure copy.
- R10: `trap_code` is 6'h03 whenever the verdict is a trap to level 2 or level 3, and 6'h00 for every other verdict.
- R11: `verdict` is one-hot for every input combination. Its bit positions are: bit 0 undefined, bit 1 trap-to-level-2, bit 2 trap-to-level-3, bit 3 virtual copy, bit 4 secure copy, bit 5 non-secure copy, bit 6 single copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| priv_lvl | input | 2 | Privilege level of the access (0 to 3) |
| hyp_on | input | 1 | Hypervisor level enabled |
| nonsec | input | 1 | Security state: 0 secure, 1 non-secure |
| in_mon_mode | input | 1 | Processor is currently in monitor mode |
| mon_impl | input | 1 | A monitor level (level 3) exists |
| mon_is32 | input | 1 | The monitor level runs in 32-bit state |
| grp_trap | input | 1 | Hypervisor register-group trap control |
| sre_lvl1 | input | 1 | System-register interface enable for level 1 |
| sre_lvl2 | input | 1 | System-register interface enable for level 2 |
| sre_lvl3 | input | 1 | System-register interface enable for level 3 |
| trap_all | input | 1 | Hypervisor trap-all control for this register group |
| virt_route | input | 1 | Interrupt routing to the hypervisor (virtual redirection) |
| irq_to_mon | input | 1 | Interrupt routing to the monitor level |
| verdict | output | 7 | One-hot classification result |
| trap_code | output | 6 | Exception-class code; 6'h03 on a trap, zero otherwise |

## Verification
The bench drives all 16384 combinations of the 14 input bits, so every position in each priority chain is reached. Along the way it reaches the cases where two or more checks would fire at the same time, and these cases show whether the checks are in the right order. The sweep includes:
- all-zero control settings, which separate the undefined and bank verdicts from the trap verdicts;
- the monitor-mode and 32-bit-monitor pairs, which separate the two forms of the level-3 trap;
- the inputs that are set but should have no effect at levels 0, 2 and 3.

An independent priority model in the bench gives the expected verdict and code for each vector.

// File: rtl/sysreg_access_pkg.sv
package sysreg_access_pkg;

    localparam int VERDICT_W = 7;
    localparam int CODE_W    = 6;
    localparam int LVL_W     = 2;
    localparam logic [CODE_W-1:0] TRAP_EC = CODE_W'(3);

    // Index of each verdict inside the one-hot vector
    typedef enum logic [2:0] {
        K_UNDEF  = 3'd0,
        K_TRAP2  = 3'd1,
        K_TRAP3  = 3'd2,
        K_VIRT   = 3'd3,
        K_SEC    = 3'd4,
        K_NSEC   = 3'd5,
        K_SINGLE = 3'd6
    } kind_e;

    // Processor and platform context of the access
    typedef struct packed {
        logic hyp_on;
        logic nonsec;
        logic in_mon_mode;
        logic mon_impl;
        logic mon_is32;
    } ctx_t;

    // Routing and trap controls
    typedef struct packed {
        logic grp_trap;
        logic trap_all;
        logic virt_route;
        logic irq_to_mon;
    } ctl_t;

    function automatic logic [VERDICT_W-1:0] to_onehot(input kind_e k);
        logic [VERDICT_W-1:0] r;
        r = '0;
        r[k] = 1'b1;
        return r;
    endfunction

    function automatic logic is_trap(input kind_e k);
        return (k == K_TRAP2) || (k == K_TRAP3);
    endfunction

    // Bank picked when a monitor level may hold separate secure/non-secure copies
    function automatic kind_e bank_pick(input logic mon_impl, input logic nonsec);
        if (!mon_impl) return K_SINGLE;
        return nonsec ? K_NSEC : K_SEC;
    endfunction

endpackage

// File: rtl/sysreg_lvl1_chain.sv
module sysreg_lvl1_chain
    import sysreg_access_pkg::*;
(
    input  ctx_t  ctx,
    input  ctl_t  ctl,
    input  logic  sre,
    output kind_e kind
);
    logic mon_trap_ok;

    always_comb begin
        // A 32-bit monitor exempts accesses made from monitor mode
        mon_trap_ok = ctx.mon_impl && ctl.irq_to_mon &&
                      !(ctx.mon_is32 && ctx.in_mon_mode);
        if (ctx.hyp_on && ctl.grp_trap)
            kind = K_TRAP2;
        else if (!sre)
            kind = K_UNDEF;
        else if (ctx.hyp_on && ctl.trap_all)
            kind = K_TRAP2;
        else if (ctx.hyp_on && ctl.virt_route)
            kind = K_VIRT;
        else if (mon_trap_ok)
            kind = K_TRAP3;
        else
            kind = bank_pick(ctx.mon_impl, ctx.nonsec);
    end

    // R2: register-group trap wins over the enable check
    always_comb begin
        if (ctx.hyp_on && ctl.grp_trap)
            a_r2_group_trap_first: assert (kind == K_TRAP2);
    end

    // R5: virtual redirection never reaches a physical bank
    always_comb begin
        if (kind == K_VIRT)
            a_r5_virt_needs_hyp: assert (ctx.hyp_on && sre);
    end

endmodule

// File: rtl/sysreg_upper_chain.sv
module sysreg_upper_chain
    import sysreg_access_pkg::*;
#(
    parameter bit IS_MONITOR = 1'b0
)(
    input  ctx_t  ctx,
    input  ctl_t  ctl,
    input  logic  sre,
    output kind_e kind
);
    generate
        if (IS_MONITOR) begin : g_lvl3
            always_comb begin
                if (!sre) kind = K_UNDEF;
                else      kind = ctx.nonsec ? K_NSEC : K_SEC;
            end
        end else begin : g_lvl2
            always_comb begin
                if (!sre)
                    kind = K_UNDEF;
                else if (ctx.mon_impl && ctl.irq_to_mon)
                    kind = K_TRAP3;
                else
                    kind = bank_pick(ctx.mon_impl, 1'b1);
            end
        end
    endgenerate

    // R8 / R9: a cleared enable always yields undefined
    always_comb begin
        if (!sre)
            a_r8_r9_enable_gate: assert (kind == K_UNDEF);
    end

endmodule

// File: rtl/sysreg_access_classifier.sv
module sysreg_access_classifier
    import sysreg_access_pkg::*;
(
    input  logic [1:0] priv_lvl,
    input  logic       hyp_on,
    input  logic       nonsec,
    input  logic       in_mon_mode,
    input  logic       mon_impl,
    input  logic       mon_is32,
    input  logic       grp_trap,
    input  logic       sre_lvl1,
    input  logic       sre_lvl2,
    input  logic       sre_lvl3,
    input  logic       trap_all,
    input  logic       virt_route,
    input  logic       irq_to_mon,
    output logic [6:0] verdict,
    output logic [5:0] trap_code
);
    ctx_t  ctx;
    ctl_t  ctl;
    kind_e k1, k2, k3, sel;

    assign ctx = '{hyp_on: hyp_on, nonsec: nonsec, in_mon_mode: in_mon_mode,
                   mon_impl: mon_impl, mon_is32: mon_is32};
    assign ctl = '{grp_trap: grp_trap, trap_all: trap_all,
                   virt_route: virt_route, irq_to_mon: irq_to_mon};

    sysreg_lvl1_chain u_lvl1 (
        .ctx  (ctx),
        .ctl  (ctl),
        .sre  (sre_lvl1),
        .kind (k1)
    );

    sysreg_upper_chain #(.IS_MONITOR(1'b0)) u_lvl2 (
        .ctx  (ctx),
        .ctl  (ctl),
        .sre  (sre_lvl2),
        .kind (k2)
    );

    sysreg_upper_chain #(.IS_MONITOR(1'b1)) u_lvl3 (
        .ctx  (ctx),
        .ctl  (ctl),
        .sre  (sre_lvl3),
        .kind (k3)
    );

    always_comb begin
        unique case (priv_lvl)
            LVL_W'(1): sel = k1;
            LVL_W'(2): sel = k2;
            LVL_W'(3): sel = k3;
            default:   sel = K_UNDEF;
        endcase
    end

    assign verdict   = to_onehot(sel);
    assign trap_code = is_trap(sel) ? TRAP_EC : '0;

    // R11: exactly one verdict bit
    always_comb begin
        a_r11_onehot: assert ($onehot(verdict));
    end

    // R1: level 0 is always undefined
    always_comb begin
        if (priv_lvl == 2'd0)
            a_r1_lvl0_undef: assert (verdict[0]);
    end

    // R10: code present exactly on trap verdicts
    always_comb begin
        a_r10_code_on_trap: assert ((trap_code == 6'h03) == (verdict[1] || verdict[2]));
    end

endmodule

// File: tb/sysreg_access_classifier_test.sv
module sysreg_access_classifier_test;

    typedef struct {
        logic [6:0] exp_v;
        logic [5:0] exp_c;
        string      req;
        int         vec;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [13:0] stim = '0;
    logic [6:0]  verdict;
    logic [5:0]  trap_code;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    item_t q[$];

    sysreg_access_classifier uut (
        .priv_lvl    (stim[1:0]),
        .hyp_on      (stim[2]),
        .nonsec      (stim[3]),
        .in_mon_mode (stim[4]),
        .mon_impl    (stim[5]),
        .mon_is32    (stim[6]),
        .grp_trap    (stim[7]),
        .sre_lvl1    (stim[8]),
        .sre_lvl2    (stim[9]),
        .sre_lvl3    (stim[10]),
        .trap_all    (stim[11]),
        .virt_route  (stim[12]),
        .irq_to_mon  (stim[13]),
        .verdict     (verdict),
        .trap_code   (trap_code)
    );

    // Reference model written from the requirements.
    // Verdict bits: 0 undef, 1 trap2, 2 trap3, 3 virt, 4 sec, 5 nsec, 6 single
    function automatic void model(input logic [13:0] s, output logic [6:0] v,
                                  output string req);
        logic hyp, ns, mm, mi, m32, gt, s1, s2, s3, ta, vr, im;
        {im, vr, ta, s3, s2, s1, gt, m32, mi, mm, ns, hyp} = s[13:2];
        case (s[1:0])
            2'd0: begin v = 7'b0000001; req = "R1"; end
            2'd1: begin
                if (hyp && gt)              begin v = 7'b0000010; req = "R2"; end
                else if (!s1)               begin v = 7'b0000001; req = "R3"; end
                else if (hyp && ta)         begin v = 7'b0000010; req = "R4"; end
                else if (hyp && vr)         begin v = 7'b0001000; req = "R5"; end
                else if (mi && im && !(m32 && mm))
                                            begin v = 7'b0000100; req = "R6"; end
                else begin
                    req = "R7";
                    v = !mi ? 7'b1000000 : (ns ? 7'b0100000 : 7'b0010000);
                end
            end
            2'd2: begin
                req = "R8";
                if (!s2)            v = 7'b0000001;
                else if (mi && im)  v = 7'b0000100;
                else                v = mi ? 7'b0100000 : 7'b1000000;
            end
            default: begin
                req = "R9";
                if (!s3) v = 7'b0000001;
                else     v = ns ? 7'b0100000 : 7'b0010000;
            end
        endcase
    endfunction

    task automatic drive(input logic [13:0] s);
        item_t it;
        @(posedge clk);
        #1;
        stim = s;
        model(s, it.exp_v, it.req);
        it.exp_c = (it.exp_v[1] || it.exp_v[2]) ? 6'h03 : 6'h00;
        it.vec   = int'(s);
        q.push_back(it);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Monitor: compares after the inputs have settled
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_checks++;
                if (verdict !== it.exp_v) begin
                    n_fail++;
                    $display("FAIL %s vec=%h verdict actual=%b expected=%b",
                             it.req, it.vec, verdict, it.exp_v);
                end
                n_checks++;
                if (trap_code !== it.exp_c) begin
                    n_fail++;
                    $display("FAIL R10 vec=%h trap_code actual=%h expected=%h",
                             it.vec, trap_code, it.exp_c);
                end
                n_checks++;
                if (!$onehot(verdict)) begin
                    n_fail++;
                    $display("FAIL R11 vec=%h verdict actual=%b expected=one-hot",
                             it.vec, verdict);
                end
            end
        end
    end

    // Driver
    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset-state check: all-zero inputs classify as undefined (R1)
        drive(14'h0000);
        for (int v = 0; v < 16384; v++) drive(14'(v));
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    // Watchdog
    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        finish_run();
    end

endmodule